// File: doc/BRIEF.md
# MII Ethernet Frame Transmitter

This block turns a byte stream carrying an Ethernet frame (destination address, source address, type/length field, payload) into nibbles on a 4-bit MII-style transmit bus. It drives one nibble per clock. It places a preamble and start delimiter ahead of the frame. It fills short frames with zero bytes up to the 64-byte minimum. It then appends the 32-bit frame check sequence (FCS), which it computes over every frame byte it has sent.

The source offers bytes with a valid flag and marks the final byte with a last flag. The block takes a byte only in a cycle where both its ready output and valid are high. Ready is raised only on the second nibble of the start delimiter or of a data byte, so the source cannot stall the wire. If the source has no byte when one is requested, the frame ends there and the block moves on to padding and FCS. After the FCS the enable stays low for an interframe gap before the next frame may begin. Addresses pass through unchanged, so frames to the broadcast address go out like any other frame.

Top module: `mii_frame_tx`

## Requirements
- R1: After reset, tx_en_o is 0, txd_o is 0 and s_ready_o is 0. While tx_en_o is 0, txd_o is 0.
- R2: A frame starts in the first cycle after an edge that sees s_valid_i high while the block is idle. Transmission opens with 7 bytes of 0x55 followed by one byte of 0xD5. tx_en_o rises together with the first preamble nibble.
- R3: Every byte takes two consecutive clocks. Bits [3:0] go out in the first clock and bits [7:4] in the second.
- R4: Input bytes are sent in the order they are accepted. A byte is accepted only on an edge where s_ready_o and s_valid_i are both high. s_ready_o is high only in the second nibble cycle of the 0xD5 byte or of a data byte whose last flag was 0.
- R5: A frame with fewer than 60 bytes of addresses, type and payload is extended with 0x00 bytes to 60 bytes before the FCS. A longer frame gets no padding.
- R6: Four FCS bytes follow the padded frame. The FCS is a CRC-32 with polynomial 0x04C11DB7, processed bit-reflected (0xEDB88320) and LSB first, with the register preset to 0xFFFFFFFF. It covers the frame bytes including padding and excludes preamble and delimiter. The result is inverted and sent least significant byte first.
- R7: A frame with destination 00:01:80:3f:6c:e6, source 01:23:45:67:89:a0 and zero content, 64 bytes long, ends with FCS bytes 75 78 03 93 in wire order. This holds whether the zeros are supplied or produced by padding.
- R8: tx_en_o stays high from the first preamble nibble through the last FCS nibble. It then stays low for at least 24 clocks. When the next frame is already waiting, it is low for exactly 25 clocks.
- R9: If s_valid_i is low in a cycle where s_ready_o is high, the frame ends after the bytes accepted so far and continues with padding and FCS. The bytes the source did not deliver are never sent.
- R10: A frame to the broadcast destination ff:ff:ff:ff:ff:ff is sent with its address bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Nibble clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_data_i | input | 8 | Frame byte from the source |
| s_valid_i | input | 1 | Source has a byte |
| s_last_i | input | 1 | Current byte is the final frame byte |
| s_ready_o | output | 1 | Byte is taken at the next edge if valid |
| txd_o | output | 4 | Transmit nibble |
| tx_en_o | output | 1 | Transmit enable |

## Verification
The first preamble nibble appears in the cycle after the edge that sees valid in idle. Every wire byte after that follows exactly two clocks behind the one before it. An accepted byte reaches txd_o one clock after the edge that took it, and the first FCS nibble follows the last frame or pad nibble with no bubble. The bench therefore samples all outputs on the falling edge, rebuilds the nibble sequence of each frame between the rise and fall of tx_en_o, and compares it byte for byte with a frame it assembles itself from preamble, data, zero padding and an independently computed CRC. The gap check counts the low falling-edge samples between two frames. Ready is counted in the same falling-edge samples so that the number of offered slots can be compared with the accepted bytes.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_PAD,
    ST_FCS,
    ST_GAP
  } tx_state_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [7:0]  PRE_BYTE      = 8'h55;
  localparam logic [7:0]  SFD_BYTE      = 8'hD5;

  // one byte through the reflected CRC-32, bit 0 first
  function automatic logic [31:0] crc32_byte(input logic [31:0] crc, input logic [7:0] b);
    logic [31:0] c;
    c = crc ^ {24'h0, b};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/mii_tx_crc.sv
module mii_tx_crc
  import mii_tx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o
);

  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (init_i) crc_q <= '1;
    else if (en_i)   crc_q <= crc32_byte(crc_q, byte_i);
  end

  assign crc_o = crc_q;

  AST_CRC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !en_i) |=> $stable(crc_o)); // R6

endmodule

// File: rtl/mii_tx_seq.sv
module mii_tx_seq
  import mii_tx_pkg::*;
#(
  parameter int PRE_BYTES = 7,
  parameter int MIN_FRAME = 64,
  parameter int IFG       = 24,
  parameter int LEN_W     = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  s_data_i,
  input  logic        s_valid_i,
  input  logic        s_last_i,
  output logic        s_ready_o,
  input  logic [31:0] crc_i,
  output logic        crc_init_o,
  output logic        crc_en_o,
  output logic [7:0]  crc_byte_o,
  output logic [7:0]  byte_o,
  output logic        hi_o,
  output logic        active_o
);

  localparam int FCS_BYTES = 4;
  localparam int MIN_BODY  = MIN_FRAME - FCS_BYTES;
  localparam int PRE_W     = $clog2(PRE_BYTES + 1);
  localparam int GAP_W     = $clog2(IFG + 1);
  localparam logic [LEN_W-1:0] BODY_MAX = '1;

  tx_state_e        state_q;
  logic             ph_q;
  logic [PRE_W-1:0] pre_q;
  logic [LEN_W-1:0] body_q;
  logic             last_q;
  logic [1:0]       fidx_q;
  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] low_run_q;
  logic [7:0]       byte_q;
  logic [31:0]      fcs_q;

  logic sfd_end, need_byte, take, end_data, body_end, short_body, pad_go, fcs_go;

  assign sfd_end    = (state_q == ST_PRE) && ph_q && (pre_q == PRE_W'(PRE_BYTES));
  assign need_byte  = sfd_end || ((state_q == ST_DATA) && ph_q && !last_q);
  assign take       = need_byte && s_valid_i;
  assign end_data   = (need_byte && !s_valid_i) || ((state_q == ST_DATA) && ph_q && last_q);
  assign body_end   = end_data || ((state_q == ST_PAD) && ph_q);
  assign short_body = body_q < LEN_W'(MIN_BODY);
  assign pad_go     = body_end && short_body;
  assign fcs_go     = body_end && !short_body;

  assign s_ready_o  = need_byte;
  assign crc_init_o = (state_q == ST_IDLE) && s_valid_i;
  assign crc_en_o   = take || pad_go;
  assign crc_byte_o = take ? s_data_i : 8'h00;
  assign active_o   = (state_q == ST_PRE) || (state_q == ST_DATA) ||
                      (state_q == ST_PAD) || (state_q == ST_FCS);
  assign byte_o     = byte_q;
  assign hi_o       = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= 1'b0;
      pre_q   <= '0;
      body_q  <= '0;
      last_q  <= 1'b0;
      fidx_q  <= '0;
      gap_q   <= '0;
      byte_q  <= '0;
      fcs_q   <= '0;
    end else begin
      if (crc_en_o && body_q != BODY_MAX) body_q <= body_q + 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (s_valid_i) begin
            state_q <= ST_PRE;
            ph_q    <= 1'b0;
            pre_q   <= '0;
            body_q  <= '0;
            last_q  <= 1'b0;
            byte_q  <= PRE_BYTE;
          end
        end
        ST_PRE, ST_DATA, ST_PAD: begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            if (state_q == ST_PRE && pre_q != PRE_W'(PRE_BYTES)) begin
              pre_q  <= pre_q + 1'b1;
              byte_q <= (pre_q == PRE_W'(PRE_BYTES - 1)) ? SFD_BYTE : PRE_BYTE;
            end else if (take) begin
              state_q <= ST_DATA;
              byte_q  <= s_data_i;
              last_q  <= s_last_i;
            end else if (pad_go) begin
              state_q <= ST_PAD;
              byte_q  <= 8'h00;
            end else if (fcs_go) begin
              state_q <= ST_FCS;
              byte_q  <= ~crc_i[7:0];
              fcs_q   <= ~crc_i;
              fidx_q  <= '0;
            end
          end
        end
        ST_FCS: begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            if (fidx_q == 2'd3) begin
              state_q <= ST_GAP;
              gap_q   <= '0;
            end else begin
              fidx_q <= fidx_q + 1'b1;
              fcs_q  <= fcs_q >> 8;
              byte_q <= fcs_q[15:8];
            end
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_W'(IFG - 1)) state_q <= ST_IDLE;
          else                          gap_q   <= gap_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // low-time tracker for the gap assertion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        low_run_q <= GAP_W'(IFG);
    else if (active_o)                  low_run_q <= '0;
    else if (low_run_q != GAP_W'(IFG))  low_run_q <= low_run_q + 1'b1;
  end

  AST_READY_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> (active_o && hi_o)); // R4
  AST_START_PREAMBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> (byte_o == PRE_BYTE && !hi_o)); // R2
  AST_SFD_BEFORE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_DATA) |-> ($past(pre_q) == PRE_W'(PRE_BYTES))); // R2
  AST_PAD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_FCS) |-> (body_q >= LEN_W'(MIN_BODY))); // R5
  AST_END_AFTER_FCS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> ($past(state_q) == ST_FCS && $past(fidx_q) == 2'd3)); // R8
  AST_GAP_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> (low_run_q >= GAP_W'(IFG))); // R8

endmodule

// File: rtl/mii_tx_nib.sv
module mii_tx_nib (
  input  logic [7:0] byte_i,
  input  logic       hi_i,
  input  logic       en_i,
  output logic [3:0] txd_o,
  output logic       tx_en_o
);

  always_comb begin
    txd_o = 4'h0;
    if (en_i) txd_o = hi_i ? byte_i[7:4] : byte_i[3:0];
  end

  assign tx_en_o = en_i;

endmodule

// File: rtl/mii_frame_tx.sv
module mii_frame_tx #(
  parameter int PRE_BYTES = 7,
  parameter int MIN_FRAME = 64,
  parameter int IFG       = 24,
  parameter int LEN_W     = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] s_data_i,
  input  logic       s_valid_i,
  input  logic       s_last_i,
  output logic       s_ready_o,
  output logic [3:0] txd_o,
  output logic       tx_en_o
);

  logic [31:0] crc;
  logic        crc_init, crc_en;
  logic [7:0]  crc_byte, cur_byte;
  logic        hi, active;

  mii_tx_seq #(
    .PRE_BYTES(PRE_BYTES),
    .MIN_FRAME(MIN_FRAME),
    .IFG      (IFG),
    .LEN_W    (LEN_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .s_data_i  (s_data_i),
    .s_valid_i (s_valid_i),
    .s_last_i  (s_last_i),
    .s_ready_o (s_ready_o),
    .crc_i     (crc),
    .crc_init_o(crc_init),
    .crc_en_o  (crc_en),
    .crc_byte_o(crc_byte),
    .byte_o    (cur_byte),
    .hi_o      (hi),
    .active_o  (active)
  );

  mii_tx_crc u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .init_i(crc_init),
    .en_i  (crc_en),
    .byte_i(crc_byte),
    .crc_o (crc)
  );

  mii_tx_nib u_nib (
    .byte_i (cur_byte),
    .hi_i   (hi),
    .en_i   (active),
    .txd_o  (txd_o),
    .tx_en_o(tx_en_o)
  );

  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_o |-> (txd_o == 4'h0 && !s_ready_o)); // R1

endmodule

// File: tb/tb_mii_frame_tx.sv
module tb_mii_frame_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] s_data = '0;
  logic       s_valid = 1'b0;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic [3:0] txd;
  logic       tx_en;

  always #4 clk = ~clk;

  mii_frame_tx dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .s_data_i (s_data),
    .s_valid_i(s_valid),
    .s_last_i (s_last),
    .s_ready_o(s_ready),
    .txd_o    (txd),
    .tx_en_o  (tx_en)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] frm [0:127];
  logic [7:0] expb [0:255];
  logic [3:0] nib [0:1023];
  int  nib_cnt   = 0;
  int  low_run   = 0;
  int  last_gap  = 0;
  bit  prev_en   = 0;
  bit  frame_done = 0;
  int  rdy_cnt   = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, expb[8 + i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  // monitor on falling edge
  always @(negedge clk) begin
    if (tx_en) begin
      if (!prev_en) begin
        nib_cnt  = 0;
        last_gap = low_run;
      end
      nib[nib_cnt] = txd;
      nib_cnt++;
      low_run = 0;
    end else begin
      low_run++;
      if (prev_en) frame_done = 1;
    end
    prev_en = tx_en;
  end

  // send frm[0..len-1]; source stops offering after drop_at bytes
  task automatic send_frame(input int len, input int drop_at, input bit chk_gap, input string req);
    int idx = 0;
    bit hs = 0;
    int acc, body, tot;
    logic [31:0] fcs;
    frame_done = 0;
    rdy_cnt = 0;
    forever begin
      @(negedge clk);
      if (hs) idx++;
      if (frame_done) break;
      if (idx < len && idx < drop_at) begin
        s_valid = 1'b1; s_data = frm[idx]; s_last = (idx == len - 1);
      end else begin
        s_valid = 1'b0; s_data = 8'h00; s_last = 1'b0;
      end
      if (s_ready) rdy_cnt++;
      hs = s_ready && s_valid;
    end
    s_valid = 1'b0; s_last = 1'b0;
    acc  = (len < drop_at) ? len : drop_at;
    body = (acc < 60) ? 60 : acc;
    for (int i = 0; i < 7; i++) expb[i] = 8'h55;
    expb[7] = 8'hD5;
    for (int i = 0; i < body; i++) expb[8 + i] = (i < acc) ? frm[i] : 8'h00;
    fcs = ref_crc(body);
    for (int i = 0; i < 4; i++) expb[8 + body + i] = fcs[8*i +: 8];
    tot = 8 + body + 4;
    // R4 R9: accepted count and offered slots
    check(idx == acc, "R4", "bytes accepted", idx, acc);
    check(rdy_cnt == acc + ((drop_at < len) ? 1 : 0), "R9", "ready slots", rdy_cnt,
          acc + ((drop_at < len) ? 1 : 0));
    // R8: enable covers exactly preamble..FCS
    check(nib_cnt == 2 * tot, "R8", "nibbles with tx_en", nib_cnt, 2 * tot);
    if (nib_cnt == 2 * tot) begin
      for (int i = 0; i < tot; i++)
        check({nib[2*i+1], nib[2*i]} == expb[i], req, $sformatf("wire byte %0d (R3)", i),
              {nib[2*i+1], nib[2*i]}, expb[i]);
    end
    if (chk_gap) check(last_gap == 25, "R8", "gap before frame", last_gap, 25);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] g [0:11];
    g = '{8'h00, 8'h01, 8'h80, 8'h3f, 8'h6c, 8'he6, 8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'ha0};
    repeat (3) @(negedge clk);
    check(tx_en == 1'b0, "R1", "tx_en in reset", tx_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_en == 1'b0 && txd == 4'h0, "R1", "idle outputs", {tx_en, txd}, 0);
    check(s_ready == 1'b0, "R1", "idle ready", s_ready, 0);

    // R5 R6: sweep frame lengths across the padding boundary
    for (int len = 1; len <= 72; len++) begin
      for (int i = 0; i < len; i++) frm[i] = 8'((i * 37 + len * 11) & 8'hFF);
      send_frame(len, 1000, len > 1, "R6");
    end

    // R7: golden frame, zeros supplied
    for (int i = 0; i < 60; i++) frm[i] = (i < 12) ? g[i] : 8'h00;
    send_frame(60, 1000, 1, "R7");
    check({nib[2*71+1], nib[2*71], nib[2*70+1], nib[2*70], nib[2*69+1], nib[2*69],
           nib[2*68+1], nib[2*68]} == 32'h93037875, "R7", "golden FCS supplied",
          {nib[2*71+1], nib[2*71], nib[2*70+1], nib[2*70]}, 16'h9303);
    // R7 R5: golden frame, zeros from padding
    send_frame(12, 1000, 1, "R7");
    check({nib[2*71+1], nib[2*71], nib[2*70+1], nib[2*70], nib[2*69+1], nib[2*69],
           nib[2*68+1], nib[2*68]} == 32'h93037875, "R7", "golden FCS padded",
          {nib[2*71+1], nib[2*71], nib[2*70+1], nib[2*70]}, 16'h9303);

    // R10: broadcast destination
    for (int i = 0; i < 20; i++) frm[i] = (i < 6) ? 8'hFF : 8'(i);
    send_frame(20, 1000, 1, "R10");

    // R9: source runs dry mid-frame and right after the delimiter
    for (int i = 0; i < 30; i++) frm[i] = 8'(8'hA0 + i);
    send_frame(30, 10, 1, "R9");
    send_frame(30, 1, 1, "R9");
    for (int i = 0; i < 70; i++) frm[i] = 8'(i ^ 8'h3C);
    send_frame(70, 65, 1, "R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule